// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches recent page translations so that a linear address can be turned into a physical address without walking the page tables. It holds 32 translations in eight sets of four ways. A lookup takes the full 32-bit linear address and answers in the same cycle. The answer is a hit flag, the 20-bit physical frame number, the physical address formed from that frame and the 12-bit page offset, and the three attribute bits stored with the entry: dirty, user-accessible and writable.

A page walker outside the block loads translations through a fill port after a miss. A write to the page-directory base register is signalled on `base_wr`. That input empties the whole buffer on the next clock edge. When a set is full, a tree pseudo-LRU policy chooses the way to replace. A write that hits an entry whose dirty bit is clear is reported as a miss. The walker can then mark the page dirty in memory and refill the entry.

Top module: `tlb_top`

## Requirements
- R1: After reset, every lookup misses (`lk_hit`=0).
- R2: A lookup that matches a valid entry sets `lk_hit` in the same cycle. On a hit, `lk_pfn` is the stored frame number and `lk_pa` is {frame, `lk_la[11:0]`}. `lk_dirty`, `lk_user` and `lk_wr_ok` carry the bits stored with the entry. On a miss, all of these outputs are zero.
- R3: Linear address bits 14:12 select one of eight sets. Each set holds four translations at once, so 32 distinct translations can all hit together.
- R4: A lookup with `lk_wr`=1 that matches an entry whose dirty bit is 0 reports a miss, with all outputs zero. A read of that same entry hits. A write to an entry whose dirty bit is 1 hits.
- R5: A fill changes nothing in the cycle it is presented. The new entry can be looked up after the next rising clock edge.
- R6: `base_wr`=1 invalidates every entry at the next rising edge. A fill presented in the same cycle is discarded.
- R7: A fill whose page number is already held in its set overwrites that entry in place. No page number is ever held twice.
- R8: A fill into a set with a free way takes the lowest-numbered free way. The first four fills into an empty set therefore use ways 0, 1, 2 and 3.
- R9: When the set is full, a fill replaces the tree pseudo-LRU victim. Each set keeps one bit per tree node. A fill or a true hit to way w sets every node on w's path to point at the other half. The victim is found by following the node bits from the root, where 0 selects the lower half. Invalidation clears the node bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_la | input | 32 | Linear address to translate |
| lk_wr | input | 1 | Lookup is for a write access |
| lk_hit | output | 1 | Usable translation found |
| lk_pa | output | 32 | Physical address on hit, else 0 |
| lk_pfn | output | 20 | Physical frame number on hit, else 0 |
| lk_dirty | output | 1 | Stored dirty bit on hit |
| lk_user | output | 1 | Stored user-accessible bit on hit |
| lk_wr_ok | output | 1 | Stored writable bit on hit |
| fl_en | input | 1 | Load a translation this cycle |
| fl_vpn | input | 20 | Virtual page number being loaded |
| fl_pfn | input | 20 | Frame number being loaded |
| fl_dirty | input | 1 | Dirty bit being loaded |
| fl_user | input | 1 | User-accessible bit being loaded |
| fl_wr_ok | input | 1 | Writable bit being loaded |
| base_wr | input | 1 | Directory base written: invalidate all |

## Verification
The replacement order is the hardest behaviour to reach from the ports. It only shows after a set is full, and every lookup that hits also moves the tree. The stimulus therefore works in a single set after a flush. It fills four pages and adds a fifth, then checks that only the first one was lost. Next it makes exactly one read hit to way 1, adds a sixth page, and checks that the page in way 2 is the one evicted. Between these steps the idle lookup address is one that never hits, so no other lookup disturbs the tree.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int LA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = LA_W - OFF_W;
    localparam int PFN_W = 20;

    typedef struct packed {
        logic dirty;
        logic user;
        logic wr_ok;
    } tlb_attr_t;
endpackage

// File: rtl/tlb_way_store.sv
`timescale 1ns/1ps
// One way of the buffer: valid bits, tags, frames and attributes for every set.
// Two combinational read ports (lookup and fill probe), one write port.
module tlb_way_store
    import tlb_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 17,
    parameter int FRM_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [FRM_W-1:0] wr_pfn,
    input  tlb_attr_t        wr_attr,
    input  logic [IDX_W-1:0] rd_set,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [FRM_W-1:0] rd_pfn,
    output tlb_attr_t        rd_attr,
    input  logic [IDX_W-1:0] pr_set,
    output logic             pr_valid,
    output logic [TAG_W-1:0] pr_tag
);
    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [FRM_W-1:0] pfn_q  [SETS];
    tlb_attr_t        attr_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_set] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q[wr_set]  <= wr_tag;
            pfn_q[wr_set]  <= wr_pfn;
            attr_q[wr_set] <= wr_attr;
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_tag   = tag_q[rd_set];
        rd_pfn   = pfn_q[rd_set];
        rd_attr  = attr_q[rd_set];
        pr_valid = valid_q[pr_set];
        pr_tag   = tag_q[pr_set];
    end

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid_q[$past(wr_set)]); // R5
endmodule

// File: rtl/tlb_plru.sv
`timescale 1ns/1ps
// Tree pseudo-LRU state for every set. Node k (heap order, root = 1) is bit k-1.
module tlb_plru #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim
);
    logic [WAYS-2:0]  tree_q     [SETS];
    logic [WAY_W-1:0] victim_all [SETS];

    function automatic logic [WAY_W-1:0] pick(input logic [WAYS-2:0] t);
        int node;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            node = node * 2 + int'(t[node-1]);
        end
        return WAY_W'(node - WAYS);
    endfunction

    function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t,
                                              input logic [WAY_W-1:0] w);
        logic [WAYS-2:0] r;
        logic            dir;
        int              node;
        r    = t;
        node = 1;
        for (int l = 0; l < WAY_W; l++) begin
            dir         = w[WAY_W-1-l];
            r[node-1]   = ~dir;
            node        = node * 2 + int'(dir);
        end
        return r;
    endfunction

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tree_q[s] <= '0;
            end else if (clr) begin
                tree_q[s] <= '0;
            end else if (touch_en && (touch_set == IDX_W'(s))) begin
                tree_q[s] <= touch(tree_q[s], touch_way);
            end
        end
        assign victim_all[s] = pick(tree_q[s]);
    end

    assign victim = victim_all[rd_set];

    AST_TOUCH_MOVES_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !clr) |=> (victim_all[$past(touch_set)] != $past(touch_way))); // R9
endmodule

// File: rtl/tlb_top.sv
`timescale 1ns/1ps
module tlb_top
    import tlb_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LA_W-1:0]  lk_la,
    input  logic             lk_wr,
    output logic             lk_hit,
    output logic [LA_W-1:0]  lk_pa,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_dirty,
    output logic             lk_user,
    output logic             lk_wr_ok,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [PFN_W-1:0] fl_pfn,
    input  logic             fl_dirty,
    input  logic             fl_user,
    input  logic             fl_wr_ok,
    input  logic             base_wr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = VPN_W - IDX_W;

    // lookup side
    logic [VPN_W-1:0] lk_vpn;
    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    // fill side
    logic [IDX_W-1:0] fl_set;
    logic [TAG_W-1:0] fl_tag;
    logic             fl_go;
    tlb_attr_t        fl_attr;

    logic [WAYS-1:0]  rd_valid, pr_valid, match, fl_match, fl_free, way_wr;
    logic [TAG_W-1:0] rd_tag [WAYS];
    logic [TAG_W-1:0] pr_tag [WAYS];
    logic [PFN_W-1:0] rd_pfn [WAYS];
    tlb_attr_t        rd_attr [WAYS];

    logic [WAY_W-1:0] hit_way, fl_way, plru_victim, match_idx, free_idx;
    logic [PFN_W-1:0] sel_pfn;
    tlb_attr_t        sel_attr;
    logic             any_match;

    assign lk_vpn  = lk_la[LA_W-1:OFF_W];
    assign lk_set  = lk_vpn[IDX_W-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
    assign fl_set  = fl_vpn[IDX_W-1:0];
    assign fl_tag  = fl_vpn[VPN_W-1:IDX_W];
    assign fl_go   = fl_en && !base_wr;
    assign fl_attr = '{dirty: fl_dirty, user: fl_user, wr_ok: fl_wr_ok};

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_way_store #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .FRM_W (PFN_W)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (base_wr),
            .wr_en    (way_wr[w]),
            .wr_set   (fl_set),
            .wr_tag   (fl_tag),
            .wr_pfn   (fl_pfn),
            .wr_attr  (fl_attr),
            .rd_set   (lk_set),
            .rd_valid (rd_valid[w]),
            .rd_tag   (rd_tag[w]),
            .rd_pfn   (rd_pfn[w]),
            .rd_attr  (rd_attr[w]),
            .pr_set   (fl_set),
            .pr_valid (pr_valid[w]),
            .pr_tag   (pr_tag[w])
        );
        assign match[w]    = rd_valid[w] && (rd_tag[w] == lk_tag);
        assign fl_match[w] = pr_valid[w] && (pr_tag[w] == fl_tag);
        assign fl_free[w]  = !pr_valid[w];
        assign way_wr[w]   = fl_go && (fl_way == WAY_W'(w));
    end

    // lookup result
    always_comb begin
        hit_way  = '0;
        sel_pfn  = '0;
        sel_attr = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                hit_way  = WAY_W'(w);
                sel_pfn  = rd_pfn[w];
                sel_attr = rd_attr[w];
            end
        end
        any_match = |match;
        lk_hit    = any_match && !(lk_wr && !sel_attr.dirty);
        lk_pfn    = lk_hit ? sel_pfn : '0;
        lk_pa     = lk_hit ? {sel_pfn, lk_la[OFF_W-1:0]} : '0;
        lk_dirty  = lk_hit && sel_attr.dirty;
        lk_user   = lk_hit && sel_attr.user;
        lk_wr_ok  = lk_hit && sel_attr.wr_ok;
    end

    // fill way choice: same page in place, else lowest free way, else tree victim
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (fl_match[w]) match_idx = WAY_W'(w);
            if (fl_free[w])  free_idx  = WAY_W'(w);
        end
        if (|fl_match)     fl_way = match_idx;
        else if (|fl_free) fl_way = free_idx;
        else               fl_way = plru_victim;
    end

    tlb_plru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_plru (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (base_wr),
        .touch_en  (fl_go || lk_hit),
        .touch_set (fl_go ? fl_set : lk_set),
        .touch_way (fl_go ? fl_way : hit_way),
        .rd_set    (fl_set),
        .victim    (plru_victim)
    );

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R7
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !lk_hit); // R6
    AST_FREE_WAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_go && !(|fl_match) && (|fl_free)) |-> fl_free[fl_way]); // R8
endmodule

// File: tb/tlb_top_tb.sv
`timescale 1ns/1ps
module tlb_top_tb;
    localparam int CLK_P = 10;
    localparam logic [31:0] IDLE_LA = 32'hFFFF_F000;

    typedef struct packed {
        logic [31:0] la;
        logic        wr;
        logic        hit;
        logic [31:0] pa;
    } vec_t;

    // expectations assume fills i=0..31 of page i+8, frame 0x50000+i, dirty=i[0]
    localparam vec_t VEC [6] = '{
        '{32'h0000_800C, 1'b0, 1'b1, 32'h5000_000C},  // R2 read hit
        '{32'h0000_800C, 1'b1, 1'b0, 32'h0000_0000},  // R4 write to clean entry
        '{32'h0000_9FFF, 1'b1, 1'b1, 32'h5000_1FFF},  // R4 write to dirty entry
        '{32'h0002_7123, 1'b0, 1'b1, 32'h5001_F123},  // R3 last entry
        '{32'h0002_8000, 1'b0, 1'b0, 32'h0000_0000},  // R2 absent page
        '{32'h8000_8000, 1'b0, 1'b0, 32'h0000_0000}   // R3 same set, other tag
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_la = IDLE_LA;
    logic        lk_wr = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [19:0] lk_pfn;
    logic        lk_dirty, lk_user, lk_wr_ok;
    logic        fl_en = 1'b0;
    logic [19:0] fl_vpn = '0;
    logic [19:0] fl_pfn = '0;
    logic        fl_dirty = 1'b0, fl_user = 1'b0, fl_wr_ok = 1'b0;
    logic        base_wr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tlb_top u_dut (
        .clk(clk), .rst_n(rst_n), .lk_la(lk_la), .lk_wr(lk_wr), .lk_hit(lk_hit),
        .lk_pa(lk_pa), .lk_pfn(lk_pfn), .lk_dirty(lk_dirty), .lk_user(lk_user),
        .lk_wr_ok(lk_wr_ok), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
        .fl_dirty(fl_dirty), .fl_user(fl_user), .fl_wr_ok(fl_wr_ok), .base_wr(base_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] la, input logic wr);
        @(negedge clk);
        lk_la = la; lk_wr = wr; fl_en = 1'b0; base_wr = 1'b0;
        #1;
    endtask

    task automatic expect_lk(input string req, input logic [31:0] la, input logic wr,
                             input logic hit, input logic [31:0] pa);
        look(la, wr);
        chk(req, {31'd0, lk_hit}, {31'd0, hit});
        chk(req, lk_pa, pa);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic d, input logic u, input logic w, input logic flush);
        @(negedge clk);
        lk_la = IDLE_LA; lk_wr = 1'b0;
        fl_en = 1'b1; fl_vpn = vpn; fl_pfn = pfn;
        fl_dirty = d; fl_user = u; fl_wr_ok = w; base_wr = flush;
        #1;
    endtask

    task automatic flush_all();
        @(negedge clk);
        lk_la = IDLE_LA; lk_wr = 1'b0; fl_en = 1'b0; base_wr = 1'b1;
        #1;
    endtask

    function automatic logic [31:0] pa_of(input logic [19:0] pfn, input logic [11:0] off);
        return {pfn, off};
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        expect_lk("R1", 32'h0000_8000, 1'b0, 1'b0, 32'h0);
        expect_lk("R1", 32'h0000_0000, 1'b0, 1'b0, 32'h0);

        // fill all 32 entries: page i+8 covers every set four times
        for (int i = 0; i < 32; i++) begin
            logic [4:0] b;
            b = 5'(i);
            fill(20'(i + 8), 20'h50000 + 20'(i), b[0], b[1], b[2], 1'b0);
        end
        // R3 / R2: all 32 coexist, attributes returned
        for (int i = 0; i < 32; i++) begin
            logic [4:0] b;
            b = 5'(i);
            look({20'(i + 8), 12'h5A5}, 1'b0);
            chk("R3", {31'd0, lk_hit}, 32'd1);
            chk("R2", lk_pa, pa_of(20'h50000 + 20'(i), 12'h5A5));
            chk("R2", {12'd0, lk_pfn}, {12'd0, 20'h50000 + 20'(i)});
            chk("R2", {29'd0, lk_dirty, lk_user, lk_wr_ok}, {29'd0, b[0], b[1], b[2]});
        end

        // vector table
        for (int v = 0; v < 6; v++) begin
            expect_lk($sformatf("R2/R3/R4 vec%0d", v), VEC[v].la, VEC[v].wr, VEC[v].hit, VEC[v].pa);
        end
        look(32'h0000_800C, 1'b1);
        chk("R4 clean write attrs zero", {28'd0, lk_dirty, lk_user, lk_wr_ok, lk_pfn == 20'd0}, 32'd1);

        // R6: flush with simultaneous fill of page 100
        fill(20'd100, 20'h0ABCD, 1'b1, 1'b1, 1'b1, 1'b1);
        expect_lk("R6 fill dropped", {20'd100, 12'h0}, 1'b0, 1'b0, 32'h0);
        for (int i = 0; i < 32; i++) begin
            expect_lk("R6 flushed", {20'(i + 8), 12'h0}, 1'b0, 1'b0, 32'h0);
        end

        // R5: not visible in the fill cycle, visible after the edge
        @(negedge clk);
        base_wr = 1'b0; fl_en = 1'b1; fl_vpn = 20'd200; fl_pfn = 20'h12345;
        fl_dirty = 1'b1; fl_user = 1'b0; fl_wr_ok = 1'b1;
        lk_la = {20'd200, 12'h010}; lk_wr = 1'b0;
        #1;
        chk("R5 same cycle", {31'd0, lk_hit}, 32'd0);
        expect_lk("R5 next cycle", {20'd200, 12'h010}, 1'b0, 1'b1, 32'h1234_5010);

        // R7 / R4: overwrite in place, clean then dirty
        fill(20'd8, 20'h11111, 1'b0, 1'b0, 1'b1, 1'b0);
        expect_lk("R4 clean write", 32'h0000_8004, 1'b1, 1'b0, 32'h0);
        expect_lk("R4 clean read", 32'h0000_8004, 1'b0, 1'b1, 32'h1111_1004);
        fill(20'd8, 20'h22222, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_lk("R7 replaced", 32'h0000_8004, 1'b1, 1'b1, 32'h2222_2004);

        // R8 / R9: replacement in set 0 after a flush
        flush_all();
        fill(20'd8,  20'h00108, 1'b0, 1'b0, 1'b0, 1'b0);  // way 0
        fill(20'd16, 20'h00110, 1'b0, 1'b0, 1'b0, 1'b0);  // way 1
        fill(20'd24, 20'h00118, 1'b0, 1'b0, 1'b0, 1'b0);  // way 2
        fill(20'd32, 20'h00120, 1'b0, 1'b0, 1'b0, 1'b0);  // way 3
        fill(20'd40, 20'h00128, 1'b0, 1'b0, 1'b0, 1'b0);  // evicts way 0
        expect_lk("R8/R9 first page evicted", {20'd8, 12'h0}, 1'b0, 1'b0, 32'h0);
        expect_lk("R9 hit way1", {20'd16, 12'h0}, 1'b0, 1'b1, 32'h0011_0000);
        fill(20'd48, 20'h00130, 1'b0, 1'b0, 1'b0, 1'b0);  // evicts way 2
        expect_lk("R9 way2 evicted", {20'd24, 12'h0}, 1'b0, 1'b0, 32'h0);
        expect_lk("R9 kept", {20'd16, 12'h0}, 1'b0, 1'b1, 32'h0011_0000);
        expect_lk("R9 kept", {20'd32, 12'h0}, 1'b0, 1'b1, 32'h0012_0000);
        expect_lk("R9 kept", {20'd40, 12'h0}, 1'b0, 1'b1, 32'h0012_8000);
        expect_lk("R9 new", {20'd48, 12'h0}, 1'b0, 1'b1, 32'h0013_0000);

        // R1: reset empties the buffer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_lk("R1 after reset", {20'd48, 12'h0}, 1'b0, 1'b0, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule